// File: doc/BRIEF.md
# Programmable Chip-Select Decoder

This block turns processor bus cycles into chip selects for external memories and peripherals. It holds eight channels. For each channel, software programs a base address, a block size, separate permission for reads and writes, the set of bus cycle types it answers, and a wait count. While address strobe is low, every channel compares the upper address bits, the transfer direction and the function code against its own settings. A matching channel pulls its active-low select line low. The block also produces an automatic data acknowledge once the programmed number of clocks has passed. If several channels match, all of them select, and the lowest-numbered one decides the acknowledge delay.

The configuration side is a synchronous write port with no read path. Each channel owns two 16-bit halves. A 16-bit write replaces one half and a 32-bit write replaces both. A byte write, a write from user mode or a misaligned write changes nothing and raises a one-clock bus-error pulse instead. There is no separate enable bit per channel. To switch a channel off, software programs it so that it can never match. Reset defines only channel 0, which after reset answers every address so that a boot device can be reached. A mode input mutes channels 0 to 3 when their pins carry address lines, and channels 4 to 7 keep working in that mode.

Top module: `csel_bank`

## Requirements
- R1: After reset, channel 0 holds base 0 with write permission, size code 15, all four cycle-type enables, read permission and wait count 15. It therefore selects on any address for reads and writes of cycle types 1, 2, 5 and 6, and acknowledges after 16 clocks.
- R2: The write port offset (`cfg_ofs`) picks the channel with bits [4:2] and the half with bit 1 (0 = upper half, 1 = lower half). The upper half holds base address bits A31..A17 in bits [15:1] and write permission in bit 0. The lower half holds the wait count in [15:12], the size code in [11:8] and the cycle-type enables in [7:4] (bit 4 = code 1, bit 5 = code 2, bit 6 = code 5, bit 7 = code 6). Read permission is in bit 0, and bits [3:1] are not stored.
- R3: A channel matches only if all three conditions hold: the enable for the current function code is set, the permission for the current direction is set (`rw`=1 means read), and every address bit outside the ignored range equals the base. Function codes 0, 3, 4 and 7 never match.
- R4: A size code N makes the compare ignore address bits A17 through A(16+N). A code of 15 ignores every base bit.
- R5: A channel with a base bit set inside its ignored range never matches.
- R6: A channel with all four cycle-type enables clear never matches. A channel with both read and write permission clear never matches either.
- R7: `cs_n[i]` is low exactly while `as_n` is low and channel i matches. Several select lines may be low at once.
- R8: With at least one match, `dtack_n` goes low after W+1 rising edges with `as_n` low, where W is the wait count of the lowest-numbered matching channel. It returns high as soon as `as_n` rises. With no match it stays high.
- R9: A 16-bit write (`cfg_size`=01) replaces only the addressed half, taken from `cfg_wdata[15:0]`. A 32-bit write (`cfg_size`=10, offset bit 1 clear) loads the upper half from [31:16] and the lower half from [15:0].
- R10: A write with `cfg_super` low, a byte write (`cfg_size`=00), code 11, offset bit 0 set, or a 32-bit write with offset bit 1 set leaves all configuration unchanged. `cfg_berr` is then high in the clock after the write edge and low otherwise.
- R11: While `cs_lo_off` is high, channels 0 to 3 never select and never set the acknowledge delay, and channels 4 to 7 behave as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| as_n | input | 1 | Address strobe, active low |
| addr | input | 32 | Bus address |
| rw | input | 1 | 1 = read, 0 = write |
| fc | input | 3 | Function code of the cycle |
| cs_lo_off | input | 1 | Mutes channels 0 to 3 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_super | input | 1 | Writer is in supervisor mode |
| cfg_size | input | 2 | 00 byte, 01 word, 10 long |
| cfg_ofs | input | 5 | Byte offset in the register page |
| cfg_wdata | input | 32 | Write data |
| cs_n | output | 8 | Active-low selects, one per channel |
| dtack_n | output | 1 | Automatic data acknowledge, active low |
| cfg_berr | output | 1 | Bus-error pulse for a refused write |

## Verification
The hardest situation to reach from the ports is an overlap, where two channels match the same cycle with different wait counts. The acknowledge must follow the lower-numbered channel even when the higher one is faster. Directed stimulus therefore programs two channels with the same base and unequal waits. It also programs a channel that is disabled only by a base bit inside its size range. Random rounds then reprogram channels at random, including refused writes. They aim addresses at the programmed bases with a few flipped bits, so that hits, near misses and overlaps all occur. A bench model predicts every select line and the acknowledge edge.

// File: rtl/csel_pkg.sv
// Shared types for the chip-select bank.
// Assumes 16-bit configuration halves, with the base field covering A31..A17.
package csel_pkg;
    localparam int BASE_LSB = 17;
    localparam int BASE_W   = 32 - BASE_LSB;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_BAD  = 2'b11
    } xfer_size_e;

    // Upper half: base address bits and write permission.
    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              wr_en;
    } cfg_hi_t;

    // Lower half as stored (the reserved bits are dropped).
    typedef struct packed {
        logic [3:0] wait_cnt;
        logic [3:0] size;
        logic [3:0] fc_en;
        logic       rd_en;
    } cfg_lo_t;
endpackage

// File: rtl/csel_regs.sv
// Configuration store for all channels, with the write port and bus-error pulse.
// Assumes NCH is a power of two, so that the offset covers the channel index exactly.
// Only channel 0 is reset. The other channels start undefined.
module csel_regs
    import csel_pkg::*;
#(
    parameter int          NCH    = 8,
    parameter logic [15:0] HI_RST = 16'h0001,
    parameter logic [15:0] LO_RST = 16'hFFF1,
    localparam int         OFS_W  = $clog2(NCH) + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_super,
    input  logic [1:0]          cfg_size,
    input  logic [OFS_W-1:0]    cfg_ofs,
    input  logic [31:0]         cfg_wdata,
    output cfg_hi_t [NCH-1:0]   hi_q,
    output cfg_lo_t [NCH-1:0]   lo_q,
    output logic                cfg_berr
);
    localparam int CH_W = OFS_W - 2;

    logic            legal;
    logic            is_long;
    logic [CH_W-1:0] ch_idx;
    cfg_hi_t         hi_d;
    cfg_lo_t         lo_d;
    logic            unused_rsvd;

    assign is_long = (xfer_size_e'(cfg_size) == SZ_LONG);
    assign legal   = cfg_super && !cfg_ofs[0] &&
                     ((xfer_size_e'(cfg_size) == SZ_WORD) || (is_long && !cfg_ofs[1]));
    assign ch_idx  = cfg_ofs[OFS_W-1:2];
    assign hi_d    = is_long ? cfg_hi_t'(cfg_wdata[31:16]) : cfg_hi_t'(cfg_wdata[15:0]);
    assign lo_d    = cfg_lo_t'({cfg_wdata[15:4], cfg_wdata[0]});
    assign unused_rsvd = ^cfg_wdata[3:1];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic    sel_i, wr_hi, wr_lo;
        cfg_hi_t hi_r;
        cfg_lo_t lo_r;

        assign sel_i   = cfg_we && legal && (ch_idx == CH_W'(i));
        assign wr_hi   = sel_i && (is_long || !cfg_ofs[1]);
        assign wr_lo   = sel_i && (is_long ||  cfg_ofs[1]);
        assign hi_q[i] = hi_r;
        assign lo_q[i] = lo_r;

        if (i == 0) begin : g_rst
            // Channel 0: reset image, then software updates.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hi_r <= cfg_hi_t'(HI_RST);
                    lo_r <= cfg_lo_t'({LO_RST[15:4], LO_RST[0]});
                end else begin
                    if (wr_hi) hi_r <= hi_d;
                    if (wr_lo) lo_r <= lo_d;
                end
            end
        end else begin : g_norst
            // Other channels: software updates only, with no reset value.
            always_ff @(posedge clk) begin
                if (wr_hi) hi_r <= hi_d;
                if (wr_lo) lo_r <= lo_d;
            end
        end
    end

    // A refused write raises the error flag for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_berr <= 1'b0;
        else        cfg_berr <= cfg_we && !legal;
    end
endmodule

// File: rtl/csel_match.sv
// Combinational compare for one channel.
// Assumes function codes 1, 2, 5 and 6 are the only cycle types that can be enabled.
module csel_match
    import csel_pkg::*;
(
    input  logic [BASE_W-1:0] base,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [3:0]        size,
    input  logic [3:0]        fc_en,
    input  logic [BASE_W-1:0] addr_hi,
    input  logic              rw,
    input  logic [2:0]        fc,
    output logic              hit
);
    logic [BASE_W-1:0] ign;
    logic              fc_ok, dir_ok, adr_ok, base_clean;

    // Build the ignored-bit mask from the size code.
    always_comb begin
        for (int k = 0; k < BASE_W; k++) ign[k] = (k < int'(size));
    end

    // Pick the enable bit for the cycle type.
    always_comb begin
        unique case (fc)
            3'd1:    fc_ok = fc_en[0];
            3'd2:    fc_ok = fc_en[1];
            3'd5:    fc_ok = fc_en[2];
            3'd6:    fc_ok = fc_en[3];
            default: fc_ok = 1'b0;
        endcase
    end

    assign dir_ok     = rw ? rd_en : wr_en;
    assign adr_ok     = (((addr_hi ^ base) & ~ign) == '0);
    assign base_clean = ((base & ign) == '0);
    assign hit        = fc_ok && dir_ok && adr_ok && base_clean;
endmodule

// File: rtl/csel_ack.sv
// Acknowledge timer. It counts clocks of a strobed cycle and releases dtack_n
// after the wait count of the lowest-numbered hit plus one.
// Assumes the hit vector is already gated by any channel muting.
module csel_ack #(
    parameter int NCH    = 8,
    parameter int WAIT_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  as_n,
    input  logic [NCH-1:0]        hits,
    input  logic [NCH*WAIT_W-1:0] waits,
    output logic                  dtack_n
);
    logic [WAIT_W-1:0] win_wait;
    logic [WAIT_W:0]   cnt;
    logic              any_hit;

    // The lowest-numbered hit wins (the loop runs downward so that it is written last).
    always_comb begin
        win_wait = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (hits[i]) win_wait = waits[i*WAIT_W +: WAIT_W];
        end
    end

    assign any_hit = |hits;

    // Clock counter for the current strobe, which saturates just past the wait.
    always_ff @(posedge clk) begin
        if (!rst_n || as_n)                cnt <= '0;
        else if (cnt <= {1'b0, win_wait}) cnt <= cnt + 1'b1;
    end

    assign dtack_n = !(!as_n && any_hit && (cnt > {1'b0, win_wait}));
endmodule

// File: rtl/csel_bank.sv
// Top of the chip-select bank: configuration store, one comparator per channel,
// select gating and the acknowledge timer.
// Assumes the bus inputs are stable while as_n is low.
module csel_bank
    import csel_pkg::*;
#(
    parameter int          NCH       = 8,
    parameter int          LOW_GROUP = 4,
    parameter logic [15:0] CH0_HI    = 16'h0001,
    parameter logic [15:0] CH0_LO    = 16'hFFF1,
    localparam int         OFS_W     = $clog2(NCH) + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             as_n,
    input  logic [31:0]      addr,
    input  logic             rw,
    input  logic [2:0]       fc,
    input  logic             cs_lo_off,
    input  logic             cfg_we,
    input  logic             cfg_super,
    input  logic [1:0]       cfg_size,
    input  logic [OFS_W-1:0] cfg_ofs,
    input  logic [31:0]      cfg_wdata,
    output logic [NCH-1:0]   cs_n,
    output logic             dtack_n,
    output logic             cfg_berr
);
    cfg_hi_t [NCH-1:0] hi_q;
    cfg_lo_t [NCH-1:0] lo_q;
    logic    [NCH-1:0] raw_hit, hits;
    logic    [NCH*4-1:0] waits;
    logic              unused_addr;

    assign unused_addr = ^addr[BASE_LSB-1:0];

    csel_regs #(.NCH(NCH), .HI_RST(CH0_HI), .LO_RST(CH0_LO)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_super(cfg_super),
        .cfg_size(cfg_size), .cfg_ofs(cfg_ofs), .cfg_wdata(cfg_wdata),
        .hi_q(hi_q), .lo_q(lo_q), .cfg_berr(cfg_berr)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        csel_match u_match (
            .base(hi_q[i].base), .wr_en(hi_q[i].wr_en), .rd_en(lo_q[i].rd_en),
            .size(lo_q[i].size), .fc_en(lo_q[i].fc_en),
            .addr_hi(addr[31:BASE_LSB]), .rw(rw), .fc(fc), .hit(raw_hit[i])
        );
        if (i < LOW_GROUP) begin : g_mutable
            assign hits[i] = raw_hit[i] && !cs_lo_off;
        end else begin : g_fixed
            assign hits[i] = raw_hit[i];
        end
        assign waits[i*4 +: 4] = lo_q[i].wait_cnt;
    end

    assign cs_n = ~(hits & {NCH{~as_n}});

    csel_ack #(.NCH(NCH), .WAIT_W(4)) u_ack (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .hits(hits), .waits(waits),
        .dtack_n(dtack_n)
    );
endmodule

// File: rtl/csel_bank_chk.sv
// Property checker for csel_bank, attached by bind.
// Assumes the default channel layout of csel_pkg.
module csel_bank_chk
    import csel_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int LOW_GROUP = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          as_n,
    input logic                          cs_lo_off,
    input logic                          cfg_we,
    input logic                          cfg_super,
    input logic [NCH-1:0]                cs_n,
    input logic                          dtack_n,
    input logic                          cfg_berr,
    input logic [NCH*$bits(cfg_hi_t)-1:0] hi_q,
    input logic [NCH*$bits(cfg_lo_t)-1:0] lo_q
);
    a_r7_idle_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |-> (&cs_n));

    a_r8_idle_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |-> dtack_n);

    a_r8_ack_with_select: assert property (@(posedge clk) disable iff (!rst_n)
        !dtack_n |-> !(&cs_n));

    a_r8_ack_not_first_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !dtack_n |-> $past(!as_n));

    a_r11_low_group_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lo_off |-> (&cs_n[LOW_GROUP-1:0]));

    a_r10_user_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_super) |=> ($stable(hi_q) && $stable(lo_q)));

    a_r10_berr_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_berr |-> $past(cfg_we));
endmodule

bind csel_bank csel_bank_chk #(.NCH(NCH), .LOW_GROUP(LOW_GROUP)) u_chk (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .cs_lo_off(cs_lo_off),
    .cfg_we(cfg_we), .cfg_super(cfg_super), .cs_n(cs_n), .dtack_n(dtack_n),
    .cfg_berr(cfg_berr), .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/csel_bank_tb.sv
// Self-checking bench for csel_bank, with a reference model of the channel settings.
module csel_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        as_n = 1'b1;
    logic [31:0] addr = '0;
    logic        rw = 1'b1;
    logic [2:0]  fc = 3'd5;
    logic        cs_lo_off = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_super = 1'b1;
    logic [1:0]  cfg_size = 2'b01;
    logic [4:0]  cfg_ofs = '0;
    logic [31:0] cfg_wdata = '0;
    logic [7:0]  cs_n;
    logic        dtack_n;
    logic        cfg_berr;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic [15:0] m_hi [8];
    logic [15:0] m_lo [8];
    logic [7:0]  known = 8'h00;

    always #10 clk = ~clk;

    csel_bank u_dut (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .addr(addr), .rw(rw), .fc(fc),
        .cs_lo_off(cs_lo_off), .cfg_we(cfg_we), .cfg_super(cfg_super),
        .cfg_size(cfg_size), .cfg_ofs(cfg_ofs), .cfg_wdata(cfg_wdata),
        .cs_n(cs_n), .dtack_n(dtack_n), .cfg_berr(cfg_berr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] lo_img(input int w, input int s, input int f, input bit r);
        return {w[3:0], s[3:0], f[3:0], 3'b000, r};
    endfunction

    function automatic logic m_hit(input int i, input logic [31:0] a, input logic r,
                                   input logic [2:0] f);
        logic [14:0] base;
        int          n;
        logic        fcok;
        base = m_hi[i][15:1];
        n    = int'(m_lo[i][11:8]);
        case (f)
            3'd1: fcok = m_lo[i][4];
            3'd2: fcok = m_lo[i][5];
            3'd5: fcok = m_lo[i][6];
            3'd6: fcok = m_lo[i][7];
            default: fcok = 1'b0;
        endcase
        for (int k = 0; k < 15; k++) begin
            if (k < n) begin
                if (base[k]) return 1'b0;
            end else if (base[k] != a[17+k]) return 1'b0;
        end
        return fcok && (r ? m_lo[i][0] : m_hi[i][0]);
    endfunction

    // One strobed bus cycle; starts and ends on a falling clock edge.
    task automatic bus_cycle(input logic [31:0] a, input logic r, input logic [2:0] f,
                             input string tag);
        logic [7:0] eh;
        int         w;
        eh = '0;
        for (int i = 0; i < 8; i++)
            if (known[i] && m_hit(i, a, r, f) && !(cs_lo_off && i < 4)) eh[i] = 1'b1;
        w = 0;
        for (int i = 7; i >= 0; i--) if (eh[i]) w = int'(m_lo[i][15:12]);
        addr = a; rw = r; fc = f; as_n = 1'b0;
        #1;
        check({tag, " R7 select"}, {24'h0, cs_n | ~known}, {24'h0, ~eh | ~known});
        check({tag, " R8 no early ack"}, {31'h0, dtack_n}, 32'h1);
        if (eh != 0 || (known != 8'hFF && m_hit(0, a, r, f) && !cs_lo_off)) begin
            repeat (w) @(negedge clk);
            check({tag, " R8 ack before wait"}, {31'h0, dtack_n}, 32'h1);
            @(negedge clk);
            check({tag, " R8 ack at wait+1"}, {31'h0, dtack_n}, 32'h0);
        end else begin
            repeat (17) @(negedge clk);
            check({tag, " R8 no ack without hit"}, {31'h0, dtack_n}, 32'h1);
        end
        as_n = 1'b1;
        #1;
        check({tag, " R8 ack drop"}, {31'h0, dtack_n}, 32'h1);
        check({tag, " R7 selects drop"}, {24'h0, cs_n}, 32'hFF);
        @(negedge clk);
    endtask

    // One configuration write, which updates the model when the write is accepted.
    task automatic cfg_write(input logic [1:0] sz, input logic [4:0] ofs,
                             input logic [31:0] d, input logic sup, input string tag);
        bit ok;
        int ch;
        ok = sup && !ofs[0] && (sz == 2'b01 || (sz == 2'b10 && !ofs[1]));
        ch = int'(ofs[4:2]);
        cfg_we = 1'b1; cfg_size = sz; cfg_ofs = ofs; cfg_wdata = d; cfg_super = sup;
        @(negedge clk);
        cfg_we = 1'b0; cfg_super = 1'b1;
        check({tag, " R10 berr pulse"}, {31'h0, cfg_berr}, {31'h0, !ok});
        if (ok) begin
            if (sz == 2'b10) begin
                m_hi[ch] = d[31:16]; m_lo[ch] = d[15:0]; known[ch] = 1'b1;
            end else if (ofs[1]) m_lo[ch] = d[15:0];
            else                 m_hi[ch] = d[15:0];
        end
        @(negedge clk);
        check({tag, " R10 berr clears"}, {31'h0, cfg_berr}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_C5A1);
        for (int i = 0; i < 8; i++) begin m_hi[i] = '0; m_lo[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 reset selects", {24'h0, cs_n}, 32'hFF);
        check("R8 reset ack", {31'h0, dtack_n}, 32'h1);
        check("R10 reset berr", {31'h0, cfg_berr}, 32'h0);

        // R1: channel 0 reset image
        m_hi[0] = 16'h0001; m_lo[0] = 16'hFFF1; known = 8'h01;
        bus_cycle(32'h1234_5678, 1'b1, 3'd5, "R1");
        bus_cycle(32'hFFF0_0000, 1'b0, 3'd1, "R1");
        bus_cycle(32'h0000_0010, 1'b1, 3'd0, "R3");

        // R9: long writes bring every channel to a known disabled state
        for (int c = 1; c < 8; c++) cfg_write(2'b10, 5'(c*4), 32'h0, 1'b1, "R9");
        // R2: channel 0 moved to page 0xFFFE with no wait
        cfg_write(2'b01, 5'h00, 32'h0000_FFFF, 1'b1, "R2");
        cfg_write(2'b01, 5'h02, {16'h0, lo_img(0, 0, 15, 1)}, 1'b1, "R2");
        bus_cycle(32'hFFFE_1000, 1'b1, 3'd2, "R2");
        bus_cycle(32'h1234_5678, 1'b1, 3'd5, "R2");

        // R3/R4: channel 1 at 0x0040_0000, size 1, wait 2
        cfg_write(2'b10, 5'h04, {15'h0020, 1'b1, lo_img(2, 1, 15, 1)}, 1'b1, "R2");
        bus_cycle(32'h0040_0000, 1'b1, 3'd5, "R4");
        bus_cycle(32'h0042_1234, 1'b0, 3'd1, "R4");
        bus_cycle(32'h0044_0000, 1'b1, 3'd5, "R3");
        bus_cycle(32'h0040_0000, 1'b1, 3'd7, "R3");

        // R5: base bit inside the ignored range
        cfg_write(2'b10, 5'h08, {15'h0061, 1'b1, lo_img(1, 1, 15, 1)}, 1'b1, "R5");
        bus_cycle(32'h00C2_0000, 1'b1, 3'd5, "R5");
        bus_cycle(32'h00C0_0000, 1'b0, 3'd5, "R5");

        // R6: cycle types all off; both directions off
        cfg_write(2'b10, 5'h0C, {15'h0100, 1'b1, lo_img(1, 0, 0, 1)}, 1'b1, "R6");
        bus_cycle(32'h0200_0000, 1'b1, 3'd5, "R6");
        cfg_write(2'b10, 5'h10, {15'h0200, 1'b0, lo_img(1, 0, 15, 0)}, 1'b1, "R6");
        bus_cycle(32'h0400_0000, 1'b1, 3'd5, "R6");
        bus_cycle(32'h0400_0000, 1'b0, 3'd6, "R6");

        // R8: overlap, the lower channel (slower) sets the delay
        cfg_write(2'b10, 5'h14, {15'h4000, 1'b1, lo_img(7, 2, 15, 1)}, 1'b1, "R8");
        cfg_write(2'b10, 5'h18, {15'h4000, 1'b1, lo_img(3, 2, 15, 1)}, 1'b1, "R8");
        bus_cycle(32'h8006_0000, 1'b1, 3'd5, "R8");

        // R4: size 15 answers everywhere for cycle type 6 only
        cfg_write(2'b10, 5'h1C, {15'h0000, 1'b1, lo_img(1, 15, 8, 1)}, 1'b1, "R4");
        bus_cycle(32'h1234_5678, 1'b1, 3'd6, "R4");
        bus_cycle(32'h1234_5678, 1'b1, 3'd5, "R4");

        // R11: low group muted, the upper group unaffected
        cs_lo_off = 1'b1;
        bus_cycle(32'h0040_0000, 1'b1, 3'd5, "R11");
        bus_cycle(32'h8006_0000, 1'b1, 3'd5, "R11");
        cs_lo_off = 1'b0;

        // R9: word write of the lower half only (wait of channel 1 becomes 5)
        cfg_write(2'b01, 5'h06, {16'hABCD, lo_img(5, 1, 15, 1)}, 1'b1, "R9");
        bus_cycle(32'h0040_0000, 1'b1, 3'd5, "R9");

        // R10: refused writes leave channel 1 as it is
        cfg_write(2'b00, 5'h04, 32'h0, 1'b1, "R10");
        cfg_write(2'b01, 5'h04, 32'h0, 1'b0, "R10");
        cfg_write(2'b10, 5'h06, 32'h0, 1'b1, "R10");
        cfg_write(2'b01, 5'h05, 32'h0, 1'b1, "R10");
        cfg_write(2'b11, 5'h04, 32'h0, 1'b1, "R10");
        bus_cycle(32'h0040_0000, 1'b1, 3'd5, "R10");

        // Random rounds
        for (int it = 0; it < 300; it++) begin
            int ch;
            logic [2:0] f;
            logic [31:0] a;
            if ($urandom_range(0, 2) == 0) begin
                logic [1:0] sz;
                logic [4:0] of;
                sz = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(0, 3)) : 2'b10;
                of = {3'($urandom_range(0, 7)), ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00};
                cfg_write(sz, of,
                          {16'($urandom), lo_img($urandom_range(0, 9), $urandom_range(0, 3),
                                                 $urandom_range(0, 15), 1'($urandom))},
                          ($urandom_range(0, 7) != 0), "R10");
            end
            ch = $urandom_range(0, 7);
            a  = {m_hi[ch][15:1], 17'($urandom)};
            if ($urandom_range(0, 3) == 0) a[17 + $urandom_range(0, 3)] ^= 1'b1;
            case ($urandom_range(0, 5))
                0: f = 3'($urandom);
                1: f = 3'd1;
                2: f = 3'd2;
                3: f = 3'd6;
                default: f = 3'd5;
            endcase
            cs_lo_off = ($urandom_range(0, 3) == 0);
            bus_cycle(a, 1'($urandom), f, "R3");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule